// File: doc/BRIEF.md
# Serial Line Break Detector

This block is the frame-level half of a serial receiver. It recognises a line break and keeps it apart from an ordinary framing error. It takes a serial input that is already synchronised, and a tick that sets the sampling rate. In asynchronous mode the tick runs at sixteen times the bit rate, and each bit is sampled at its centre. In synchronous mode each tick is one bit sample. Each frame has a start bit, eight data bits sent LSB first, an optional parity bit and one stop bit.

A frame whose data, parity and stop bits are all low is a break. It raises a sticky break flag in the same clock edge that samples the low stop bit. The framing-error flag stays clear for such a frame. The receiver then stays in a break state: it does not hunt for start bits and delivers no characters. It leaves that state only when the line has been high long enough. In asynchronous mode that means two consecutive ticks. In synchronous mode one high sample is enough. Leaving the break state raises the break flag again, so software that cleared the flag at the start of the break sees the end of it as well. A one-cycle clear-status pulse resets both flags.

A frame whose stop bit is low but whose data is non-zero, or whose parity bit is high, is a framing error. A frame with a high stop bit is delivered as a character on a one-cycle valid strobe.

Top module: `uart_brk_rx`

## Requirements
- R1: A frame whose eight data bits, parity bit (when parity is enabled) and stop bit are all sampled low sets `brk_flag_o`. The flag is visible in the cycle after the clock edge that samples the stop bit.
- R2: A break frame never sets `frame_err_o`.
- R3: A frame with a low stop bit and either non-zero data or a high parity bit sets `frame_err_o` and leaves `brk_flag_o` unchanged.
- R4: Both flags stay set until a one-cycle pulse on `clr_status_i` clears them. A clear pulse in a cycle with no new event leaves both flags at 0.
- R5: In asynchronous mode, the break ends after two consecutive ticks with the line high. A single high tick followed by a low tick does not end the break.
- R6: In synchronous mode, a single tick with the line high ends the break.
- R7: The end of a break sets `brk_flag_o` again. Until that end, no start bit is recognised and `rx_valid_o` stays low.
- R8: A frame with a high stop bit pulses `rx_valid_o` for one cycle. `rx_data_o` then holds the data, with the first data bit received in bit 0. Neither flag changes.
- R9: In asynchronous mode, a start bit is confirmed only if the line is still low at the eighth tick after the low level was first seen. Otherwise the receiver goes back to idle and reports nothing.
- R10: After reset, `brk_flag_o`, `frame_err_o` and `rx_valid_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd_i | input | 1 | Synchronised serial line, idle high |
| tick_i | input | 1 | One-cycle sample tick (16 per bit asynchronous, 1 per bit synchronous) |
| sync_mode_i | input | 1 | 1 = synchronous (one sample per bit), 0 = asynchronous 16x |
| parity_en_i | input | 1 | 1 = frame carries a parity bit after the data |
| clr_status_i | input | 1 | One-cycle pulse that clears both status flags |
| brk_flag_o | output | 1 | Sticky flag, set at break start and again at break end |
| frame_err_o | output | 1 | Sticky framing-error flag |
| rx_valid_o | output | 1 | One-cycle strobe for a received character |
| rx_data_o | output | 8 | Received character, first bit in bit 0 |

## Verification
The assertions assume the following about the inputs:
- `tick_i` is a single-cycle pulse.
- `sync_mode_i` and `parity_en_i` change only while the line idles high.
- A clear pulse never lands in the same cycle as a break or framing event.

The stimulus keeps within these limits in several ways. It spaces ticks four clocks apart and changes the line only between ticks. It switches mode and parity only between frames. It issues clears only on an idle line or in the middle of a long low break.

// File: rtl/uart_brk_pkg.sv
package uart_brk_pkg;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP,
        RX_BRK
    } rx_state_e;

    typedef struct packed {
        logic brk_set;
        logic ferr_set;
    } rx_event_t;

    // A low stop bit after all-zero data and a low (or absent) parity bit.
    function automatic logic frame_is_break(input logic data_zero,
                                            input logic par_en,
                                            input logic par_bit);
        return data_zero && !(par_en && par_bit);
    endfunction

endpackage

// File: rtl/ubrk_bit_timer.sv
module ubrk_bit_timer #(
    parameter int OSR = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic sync_i,
    input  logic restart_i,
    output logic samp_o
);
    localparam int CNT_W = (OSR > 1) ? $clog2(OSR) : 1;
    localparam logic [CNT_W-1:0] MID  = CNT_W'(OSR / 2 - 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OSR - 1);

    logic [CNT_W-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
        end else if (restart_i) begin
            phase_q <= '0;
        end else if (tick_i) begin
            phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
        end
    end

    assign samp_o = tick_i && (sync_i || phase_q == MID);

endmodule

// File: rtl/ubrk_frame_fsm.sv
module ubrk_frame_fsm
    import uart_brk_pkg::*;
#(
    parameter int DATA_BITS      = 8,
    parameter int END_HIGH_TICKS = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rxd_i,
    input  logic                 tick_i,
    input  logic                 samp_i,
    input  logic                 sync_i,
    input  logic                 par_en_i,
    output logic                 restart_o,
    output rx_event_t            event_o,
    output logic                 valid_o,
    output logic [DATA_BITS-1:0] data_o
);
    localparam int IDX_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
    localparam int HI_W  = $clog2(END_HIGH_TICKS + 1);
    localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(DATA_BITS - 1);
    localparam logic [HI_W:0]    THR_ASYNC = (HI_W + 1)'(END_HIGH_TICKS);
    localparam logic [HI_W:0]    THR_SYNC  = (HI_W + 1)'(1);

    rx_state_e             state_q;
    logic [IDX_W-1:0]      idx_q;
    logic [DATA_BITS-1:0]  shreg_q;
    logic                  par_q;
    logic [HI_W-1:0]       hi_q;
    logic                  valid_q;
    logic [DATA_BITS-1:0]  data_q;

    logic                  stop_low;
    logic                  is_brk;
    logic [HI_W:0]         hi_next;
    logic                  end_hit;

    always_comb begin
        stop_low = (state_q == RX_STOP) && samp_i && !rxd_i;
        is_brk   = frame_is_break(shreg_q == '0, par_en_i, par_q);
        hi_next  = {1'b0, hi_q} + 1'b1;
        end_hit  = (state_q == RX_BRK) && tick_i && rxd_i &&
                   (hi_next >= (sync_i ? THR_SYNC : THR_ASYNC));
        event_o.brk_set  = (stop_low && is_brk) || end_hit;
        event_o.ferr_set = stop_low && !is_brk;
        restart_o        = (state_q == RX_IDLE) && tick_i && !rxd_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RX_IDLE;
            idx_q   <= '0;
            shreg_q <= '0;
            par_q   <= 1'b0;
            hi_q    <= '0;
            valid_q <= 1'b0;
            data_q  <= '0;
        end else begin
            valid_q <= 1'b0;
            case (state_q)
                RX_IDLE: begin
                    if (tick_i && !rxd_i) begin
                        idx_q   <= '0;
                        par_q   <= 1'b0;
                        state_q <= sync_i ? RX_DATA : RX_START;
                    end
                end
                RX_START: begin
                    if (samp_i) begin
                        state_q <= rxd_i ? RX_IDLE : RX_DATA;
                    end
                end
                RX_DATA: begin
                    if (samp_i) begin
                        shreg_q <= {rxd_i, shreg_q[DATA_BITS-1:1]};
                        if (idx_q == LAST_IDX) begin
                            state_q <= par_en_i ? RX_PAR : RX_STOP;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
                RX_PAR: begin
                    if (samp_i) begin
                        par_q   <= rxd_i;
                        state_q <= RX_STOP;
                    end
                end
                RX_STOP: begin
                    if (samp_i) begin
                        if (rxd_i) begin
                            valid_q <= 1'b1;
                            data_q  <= shreg_q;
                            state_q <= RX_IDLE;
                        end else if (is_brk) begin
                            hi_q    <= '0;
                            state_q <= RX_BRK;
                        end else begin
                            state_q <= RX_IDLE;
                        end
                    end
                end
                RX_BRK: begin
                    if (tick_i) begin
                        if (!rxd_i) begin
                            hi_q <= '0;
                        end else if (end_hit) begin
                            state_q <= RX_IDLE;
                        end else begin
                            hi_q <= hi_next[HI_W-1:0];
                        end
                    end
                end
                default: state_q <= RX_IDLE;
            endcase
        end
    end

    assign valid_o = valid_q;
    assign data_o  = data_q;

    // While in break, no character is delivered (R7).
    assert_no_char_in_brk_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q == RX_BRK) |-> !valid_q);

    // Without a high tick the break state is kept (R7).
    assert_brk_held_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q == RX_BRK && !(tick_i && rxd_i)) |=> (state_q == RX_BRK));

    // Synchronous mode: one high sample ends the break (R6).
    assert_sync_end_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == RX_BRK && sync_i && tick_i && rxd_i) |=> (state_q == RX_IDLE));

    // Asynchronous mode: the first high tick alone does not end the break (R5).
    assert_async_one_high_R5: assert property (@(posedge clk) disable iff (rst)
        (END_HIGH_TICKS > 1 && state_q == RX_BRK && !sync_i && hi_q == '0 &&
         tick_i && rxd_i) |=> (state_q == RX_BRK));

    // Character strobe lasts one cycle (R8).
    assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        valid_q |=> !valid_q);

endmodule

// File: rtl/ubrk_status.sv
module ubrk_status
    import uart_brk_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  rx_event_t event_i,
    input  logic      clr_i,
    output logic      brk_o,
    output logic      ferr_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            brk_o  <= 1'b0;
            ferr_o <= 1'b0;
        end else begin
            if (event_i.brk_set)       brk_o  <= 1'b1;
            else if (clr_i)            brk_o  <= 1'b0;
            if (event_i.ferr_set)      ferr_o <= 1'b1;
            else if (clr_i)            ferr_o <= 1'b0;
        end
    end

    // A break and a framing error are never reported by one frame (R2).
    assert_brk_not_ferr_R2: assert property (@(posedge clk) disable iff (rst)
        !(event_i.brk_set && event_i.ferr_set));

    // Flags are sticky without a clear (R4).
    assert_brk_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        (brk_o && !clr_i) |=> brk_o);

    assert_ferr_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        (ferr_o && !clr_i) |=> ferr_o);

    // A clear with no new event empties both flags (R4).
    assert_clear_R4: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !event_i.brk_set && !event_i.ferr_set) |=> (!brk_o && !ferr_o));

endmodule

// File: rtl/uart_brk_rx.sv
module uart_brk_rx
    import uart_brk_pkg::*;
#(
    parameter int DATA_BITS      = 8,
    parameter int OSR            = 16,
    parameter int END_HIGH_TICKS = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rxd_i,
    input  logic                 tick_i,
    input  logic                 sync_mode_i,
    input  logic                 parity_en_i,
    input  logic                 clr_status_i,
    output logic                 brk_flag_o,
    output logic                 frame_err_o,
    output logic                 rx_valid_o,
    output logic [DATA_BITS-1:0] rx_data_o
);
    logic      samp;
    logic      restart;
    rx_event_t evt;

    ubrk_bit_timer #(.OSR(OSR)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .tick_i    (tick_i),
        .sync_i    (sync_mode_i),
        .restart_i (restart),
        .samp_o    (samp)
    );

    ubrk_frame_fsm #(
        .DATA_BITS      (DATA_BITS),
        .END_HIGH_TICKS (END_HIGH_TICKS)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .rxd_i     (rxd_i),
        .tick_i    (tick_i),
        .samp_i    (samp),
        .sync_i    (sync_mode_i),
        .par_en_i  (parity_en_i),
        .restart_o (restart),
        .event_o   (evt),
        .valid_o   (rx_valid_o),
        .data_o    (rx_data_o)
    );

    ubrk_status u_status (
        .clk     (clk),
        .rst     (rst),
        .event_i (evt),
        .clr_i   (clr_status_i),
        .brk_o   (brk_flag_o),
        .ferr_o  (frame_err_o)
    );

endmodule

// File: tb/test_uart_brk_rx.sv
module test_uart_brk_rx;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst = 1'b1;
    logic       rxd = 1'b1;
    logic       tick = 1'b0;
    logic       sync_mode = 1'b0;
    logic       par_en = 1'b0;
    logic       clr = 1'b0;
    logic       brk, ferr, valid;
    logic [7:0] data;

    uart_brk_rx i_uart_brk_rx (
        .clk          (clk),
        .rst          (rst),
        .rxd_i        (rxd),
        .tick_i       (tick),
        .sync_mode_i  (sync_mode),
        .parity_en_i  (par_en),
        .clr_status_i (clr),
        .brk_flag_o   (brk),
        .frame_err_o  (ferr),
        .rx_valid_o   (valid),
        .rx_data_o    (data)
    );

    int n_run = 0;
    int n_fail = 0;
    int div = 0;
    bit done = 0;
    bit seen_valid = 0;
    int seen_data = 0;

    // reference model state
    int m_phase = 0;   // 0 idle, 1 in frame, 2 in break
    int m_t = 0;
    int m_hi = 0;
    int m_data = 0;
    bit m_par = 0;
    bit e_brk = 0, e_ferr = 0, e_valid = 0;
    int e_data = 0;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic model_update();
        int k;
        bit set_b, set_f;
        set_b = 0;
        set_f = 0;
        e_valid = 0;
        if (rst) begin
            m_phase = 0; e_brk = 0; e_ferr = 0;
            return;
        end
        if (tick) begin
            if (m_phase == 0) begin
                if (!rxd) begin
                    m_phase = 1; m_t = 0; m_data = 0; m_par = 0;
                end
            end else if (m_phase == 1) begin
                m_t++;
                k = -1;
                if (sync_mode) k = m_t;
                else if (m_t % 16 == 8) k = m_t / 16;
                if (k == 0) begin
                    if (rxd) m_phase = 0;
                end else if (k >= 1 && k <= 8) begin
                    if (rxd) m_data = m_data | (1 << (k - 1));
                end else if (k == 9 && par_en) begin
                    m_par = rxd;
                end else if (k > 0) begin
                    m_phase = 0;
                    if (rxd) begin
                        e_valid = 1; e_data = m_data;
                    end else if (m_data == 0 && !m_par) begin
                        set_b = 1; m_phase = 2; m_hi = 0;
                    end else begin
                        set_f = 1;
                    end
                end
            end else begin
                if (rxd) begin
                    m_hi++;
                    if (m_hi >= (sync_mode ? 1 : 2)) begin
                        set_b = 1; m_phase = 0;
                    end
                end else begin
                    m_hi = 0;
                end
            end
        end
        if (set_b) e_brk = 1; else if (clr) e_brk = 0;
        if (set_f) e_ferr = 1; else if (clr) e_ferr = 0;
    endtask

    // Inputs for the coming edge are final when step is called.
    task automatic step();
        div = (div + 1) % 4;
        tick = (div == 0);
        model_update();
        @(negedge clk);
        check("R1", "model brk_flag", brk, e_brk);
        check("R3", "model frame_err", ferr, e_ferr);
        check("R8", "model rx_valid", valid, e_valid);
        if (e_valid) check("R8", "model rx_data", data, e_data);
        if (valid) begin
            seen_valid = 1; seen_data = data;
        end
    endtask

    task automatic hold(input bit v, input int n);
        int cnt;
        rxd = v;
        cnt = 0;
        while (cnt < n) begin
            step();
            if (tick) cnt++;
        end
    endtask

    task automatic send_frame(input logic [7:0] d, input bit pb, input bit stop, input int bt);
        hold(0, bt);
        for (int i = 0; i < 8; i++) hold(d[i], bt);
        if (par_en) hold(pb, bt);
        hold(stop, bt);
    endtask

    task automatic pulse_clr();
        clr = 1; step();
        clr = 0; step();
    endtask

    initial begin
        repeat (4) step();
        check("R10", "brk after reset", brk, 0);
        check("R10", "ferr after reset", ferr, 0);
        check("R10", "valid after reset", valid, 0);
        rst = 0;
        hold(1, 4);

        // R8 asynchronous character
        seen_valid = 0;
        send_frame(8'hA5, 0, 1, 16);
        hold(1, 20);
        check("R8", "async valid seen", seen_valid, 1);
        check("R8", "async data", seen_data, 8'hA5);
        check("R8", "no brk on good frame", brk, 0);

        // R9 short low pulse is not a start bit
        seen_valid = 0;
        hold(0, 4);
        hold(1, 60);
        check("R9", "false start valid", seen_valid, 0);
        check("R9", "false start ferr", ferr, 0);

        // R3 low stop with non-zero data
        send_frame(8'h10, 0, 0, 16);
        hold(1, 20);
        check("R3", "ferr on nonzero data", ferr, 1);
        check("R3", "no brk on nonzero data", brk, 0);
        pulse_clr();
        check("R4", "ferr cleared", ferr, 0);

        // R3 zero data but high parity
        par_en = 1;
        send_frame(8'h00, 1, 0, 16);
        hold(1, 20);
        check("R3", "ferr on high parity", ferr, 1);
        check("R3", "no brk on high parity", brk, 0);
        pulse_clr();

        // R1 R2 asynchronous break with parity
        send_frame(8'h00, 0, 0, 16);
        hold(0, 30);
        check("R1", "async brk set", brk, 1);
        check("R2", "no ferr on break", ferr, 0);
        hold(0, 200);
        check("R4", "brk sticky", brk, 1);
        pulse_clr();
        check("R4", "brk cleared", brk, 0);

        // R5 R7 one-tick high pulses do not end the break
        seen_valid = 0;
        for (int j = 0; j < 3; j++) begin
            hold(1, 1);
            hold(0, 40);
        end
        check("R5", "1/16 high keeps break", brk, 0);
        check("R7", "no char in break", seen_valid, 0);
        check("R7", "no ferr in break", ferr, 0);
        hold(1, 2);
        check("R5", "2/16 high ends break", brk, 1);
        check("R7", "end sets brk again", brk, 1);
        hold(1, 20);
        pulse_clr();
        par_en = 0;

        // R8 reception resumes after a break
        seen_valid = 0;
        send_frame(8'h5A, 0, 1, 16);
        hold(1, 20);
        check("R8", "char after break", seen_data, 8'h5A);
        check("R8", "valid after break", seen_valid, 1);

        // synchronous mode
        sync_mode = 1;
        hold(1, 4);
        send_frame(8'h00, 0, 0, 1);
        hold(0, 6);
        check("R1", "sync brk set", brk, 1);
        check("R2", "sync no ferr", ferr, 0);
        pulse_clr();
        hold(0, 3);
        check("R4", "sync brk cleared", brk, 0);
        hold(1, 1);
        check("R6", "single high ends break", brk, 1);
        hold(1, 6);
        pulse_clr();

        send_frame(8'h80, 0, 0, 1);
        hold(1, 4);
        check("R3", "sync ferr", ferr, 1);
        check("R3", "sync no brk", brk, 0);
        pulse_clr();

        seen_valid = 0;
        send_frame(8'h3C, 0, 1, 1);
        hold(1, 4);
        check("R8", "sync valid", seen_valid, 1);
        check("R8", "sync data", seen_data, 8'h3C);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL R10 watchdog expired: actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule